// File: doc/BRIEF.md
# Multi-Target Edge Synchronizer

This block lines up a local trigger across several devices that share one open, pulled-low signal line and a common slow timing reference. Each device runs its own fast clock; the timing reference and the shared line reach it as asynchronous levels and are resynchronized inside. One instance is configured as master. When its local trigger rises, it waits for the next falling edge of the reference and then drives the shared line high for one full reference period. The line is driven only through a drive-enable output, which the pad turns into a high or a released line.

Every instance, the master included, watches the shared line. After it sees the line asserted, it emits a single-cycle synchronized pulse at the next reference edge of either polarity, so all devices fire on the same reference transition. While a distribution is in flight, the master ignores further triggers. It also reports how many clock cycles the alignment added. With synchronization disabled, the block acts as a plain rising-edge detector on the trigger.

Top module: `edge_sync_node`

## Requirements
- R1: The trigger input passes through a rising-edge detector, so a trigger held high for many cycles produces exactly one synchronized pulse.
- R2: On the master with enable high, an accepted trigger raises `bus_drive_en` one cycle after the first synchronized reference falling strobe that follows acceptance. The driver is held for one full reference period and dropped one cycle after the next falling strobe.
- R3: With `is_master` low, `bus_drive_en` stays low and the trigger input has no effect on `sync_pulse` while enable is high.
- R4: Each instance samples the shared line through a two-stage synchronizer. `sync_pulse` goes high for one cycle after the first synchronized reference edge (rising or falling) that follows the synchronized line reading high. It fires once per assertion of the line.
- R5: After the master accepts a trigger, further trigger edges are ignored until it has released the line and reads the line low again.
- R6: `delay_cycles` on the master holds the number of clock edges from the edge that accepted the trigger to the edge that raised `sync_pulse`, minus one.
- R7: With enable low, `delay_cycles` is 0 and `bus_drive_en` is low. `sync_pulse` is high for the one cycle after a trigger rise.
- R8: While reset is held, and until the internal reset release two clocks after deassertion, `bus_drive_en`, `sync_pulse` and `delay_cycles` are all 0.
- R9: `sync_pulse` is never high on two consecutive cycles while enable stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| is_master | input | 1 | Configures this instance as the master |
| enable | input | 1 | Enables synchronization; low gives a plain edge detector |
| trig_in | input | 1 | Local trigger, synchronous to clk |
| ref_in | input | 1 | Shared timing reference, asynchronous level |
| line_in | input | 1 | Level read back from the shared line, asynchronous |
| bus_drive_en | output | 1 | High: drive the shared line high; low: leave it released |
| sync_pulse | output | 1 | Single-cycle synchronized trigger |
| delay_cycles | output | DELAY_W | Clock cycles added by synchronization (master only) |

## Verification
On the master, accepting a trigger and a reference falling strobe can land on the same cycle. Acceptance must win, and the drive must wait for the following fall. A new trigger can also arrive while the master is still locked out. The bench sweeps the trigger across all sixteen phases of the reference period and fires retriggers inside the lockout window. On every clock it compares the drive, the pulse and the reported latency against a behavioural model. It also counts the pulses in each window and requires exactly one.

// File: rtl/esn_pkg.sv
package esn_pkg;
  typedef enum logic [1:0] {
    MST_IDLE  = 2'd0,
    MST_ARMED = 2'd1,
    MST_DRIVE = 2'd2,
    MST_DRAIN = 2'd3
  } mst_state_e;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_SEEN = 2'd1,
    RX_DONE = 2'd2
  } rx_state_e;
endpackage

// File: rtl/esn_sync_chain.sv
module esn_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b0;
        else        s_q <= d;
      end
      assign q = s_q;
    end else begin : g_chain
      logic [STAGES-1:0] sr_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[STAGES-2:0], d};
      end
      assign q = sr_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/esn_edge_det.sv
module esn_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise,
  output logic fall
);
  logic prev_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig;
  end
  assign rise = sig & ~prev_q;
  assign fall = ~sig & prev_q;
endmodule

// File: rtl/esn_master_ctl.sv
module esn_master_ctl
  import esn_pkg::*;
#(
  parameter int DELAY_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               active,
  input  logic               trig_rise,
  input  logic               ref_fall,
  input  logic               line_lvl,
  input  logic               rx_fire,
  output logic               drive,
  output logic [DELAY_W-1:0] delay
);
  localparam logic [DELAY_W-1:0] CNT_MAX = '1;

  mst_state_e st_q, st_d;
  logic [DELAY_W-1:0] cnt_q, cnt_d, dly_q, dly_d;
  logic counting_q, counting_d;
  logic accept, dly_en;

  assign accept = active && (st_q == MST_IDLE) && trig_rise;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      MST_IDLE:  if (trig_rise)  st_d = MST_ARMED;
      MST_ARMED: if (ref_fall)   st_d = MST_DRIVE;
      MST_DRIVE: if (ref_fall)   st_d = MST_DRAIN;
      MST_DRAIN: if (!line_lvl)  st_d = MST_IDLE;
      default:                   st_d = MST_IDLE;
    endcase
    if (!active) st_d = MST_IDLE;
  end

  always_comb begin
    cnt_d      = cnt_q;
    counting_d = counting_q;
    dly_d      = dly_q;
    dly_en     = 1'b0;
    if (!enable) begin
      cnt_d      = '0;
      counting_d = 1'b0;
      dly_d      = '0;
      dly_en     = 1'b1;
    end else if (!active) begin
      counting_d = 1'b0;
    end else if (accept) begin
      cnt_d      = '0;
      counting_d = 1'b1;
    end else if (counting_q) begin
      if (rx_fire) begin
        dly_d      = cnt_q;
        dly_en     = 1'b1;
        counting_d = 1'b0;
      end else if (cnt_q != CNT_MAX) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= MST_IDLE;
      cnt_q      <= '0;
      counting_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      counting_q <= counting_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dly_q <= '0;
    else if (dly_en) dly_q <= dly_d;
  end

  assign drive = (st_q == MST_DRIVE);
  assign delay = dly_q;
endmodule

// File: rtl/esn_rx.sv
module esn_rx
  import esn_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic trig_rise,
  input  logic line_lvl,
  input  logic ref_edge,
  output logic fire,
  output logic pulse
);
  rx_state_e st_q, st_d;
  logic pulse_d, pulse_q;

  assign fire = enable && (st_q == RX_SEEN) && ref_edge;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      RX_IDLE: if (line_lvl)  st_d = RX_SEEN;
      RX_SEEN: if (ref_edge)  st_d = RX_DONE;
      RX_DONE: if (!line_lvl) st_d = RX_IDLE;
      default:                st_d = RX_IDLE;
    endcase
    if (!enable) st_d = RX_IDLE;
    pulse_d = enable ? fire : trig_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/edge_sync_node.sv
module edge_sync_node #(
  parameter int SYNC_STAGES = 2,
  parameter int DELAY_W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               is_master,
  input  logic               enable,
  input  logic               trig_in,
  input  logic               ref_in,
  input  logic               line_in,
  output logic               bus_drive_en,
  output logic               sync_pulse,
  output logic [DELAY_W-1:0] delay_cycles
);
  logic [1:0] rst_sr_q;
  logic       rst_i_n;
  logic       ref_s, line_s, ref_rise, ref_fall;
  logic       trig_q, trig_rise, rx_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr_q <= 2'b00;
    else        rst_sr_q <= {rst_sr_q[0], 1'b1};
  end
  assign rst_i_n = rst_sr_q[1];

  esn_sync_chain #(.STAGES(SYNC_STAGES)) u_ref_sync (
    .clk(clk), .rst_n(rst_i_n), .d(ref_in), .q(ref_s)
  );
  esn_sync_chain #(.STAGES(SYNC_STAGES)) u_line_sync (
    .clk(clk), .rst_n(rst_i_n), .d(line_in), .q(line_s)
  );
  esn_edge_det u_ref_edge (
    .clk(clk), .rst_n(rst_i_n), .sig(ref_s), .rise(ref_rise), .fall(ref_fall)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) trig_q <= 1'b0;
    else          trig_q <= trig_in;
  end
  assign trig_rise = trig_in & ~trig_q;

  esn_master_ctl #(.DELAY_W(DELAY_W)) u_master (
    .clk(clk), .rst_n(rst_i_n), .enable(enable),
    .active(enable & is_master), .trig_rise(trig_rise),
    .ref_fall(ref_fall), .line_lvl(line_s), .rx_fire(rx_fire),
    .drive(bus_drive_en), .delay(delay_cycles)
  );

  esn_rx u_rx (
    .clk(clk), .rst_n(rst_i_n), .enable(enable), .trig_rise(trig_rise),
    .line_lvl(line_s), .ref_edge(ref_rise | ref_fall),
    .fire(rx_fire), .pulse(sync_pulse)
  );
endmodule

// File: rtl/esn_checker.sv
module esn_checker #(
  parameter int DELAY_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               is_master,
  input logic               enable,
  input logic               bus_drive_en,
  input logic               sync_pulse,
  input logic [DELAY_W-1:0] delay_cycles,
  input logic               ref_fall
);
  assert_drive_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_drive_en) |-> $past(ref_fall));

  assert_release_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_drive_en) && $past(is_master) && $past(enable)) |-> $past(ref_fall));

  assert_slave_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |=> !bus_drive_en);

  assert_delay_zero_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (delay_cycles == '0 && !bus_drive_en));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse && enable) |=> !sync_pulse);
endmodule

bind edge_sync_node esn_checker #(.DELAY_W(DELAY_W)) u_esn_checker (
  .clk(clk), .rst_n(rst_n), .is_master(is_master), .enable(enable),
  .bus_drive_en(bus_drive_en), .sync_pulse(sync_pulse),
  .delay_cycles(delay_cycles), .ref_fall(ref_fall)
);

// File: tb/tb_edge_sync_node.sv
module tb_edge_sync_node;
  localparam int CLK_PERIOD = 10;
  localparam int REF_HALF   = 8;
  localparam int DW         = 16;
  localparam int MAXV       = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0, is_master = 1'b0, enable = 1'b0, trig = 1'b0;
  logic ext_line = 1'b0, ref_sig = 1'b0;
  logic dut_drive, dut_pulse;
  logic [DW-1:0] dut_delay;
  wire  line = dut_drive | ext_line;

  int tests = 0, fails = 0, refc = 0, obs = 0, drive_hi = 0;
  bit cmp_on = 0, prev_pulse = 0, done = 0;

  // model state
  int rs_hi = 0, m_st = 0, r_st = 0, m_cnt = 0, m_delay = 0;
  bit m_counting = 0, m_pulse = 0, m_drive = 0;
  bit hr0 = 0, hr1 = 0, hr2 = 0, hl0 = 0, hl1 = 0, tq = 0;
  bit t_r, r_r, r_f, lvl, act, fire, acc, lin;

  edge_sync_node #(.SYNC_STAGES(2), .DELAY_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .enable(enable),
    .trig_in(trig), .ref_in(ref_sig), .line_in(line),
    .bus_drive_en(dut_drive), .sync_pulse(dut_pulse), .delay_cycles(dut_delay)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (refc == REF_HALF - 1) begin refc <= 0; ref_sig <= ~ref_sig; end
    else refc <= refc + 1;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act_v, input int exp_v);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act_v, exp_v);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    lin = m_drive | ext_line;
    if (!rst_n) rs_hi = 0;
    if (!rst_n || rs_hi < 2) begin
      hr0 = 0; hr1 = 0; hr2 = 0; hl0 = 0; hl1 = 0; tq = 0;
      m_st = 0; r_st = 0; m_cnt = 0; m_delay = 0;
      m_counting = 0; m_pulse = 0; m_drive = 0;
      if (rst_n) rs_hi++;
    end else begin
      t_r  = trig & ~tq;
      r_r  = hr1 & ~hr2;
      r_f  = ~hr1 & hr2;
      lvl  = hl1;
      act  = enable & is_master;
      fire = enable && r_st == 1 && (r_r || r_f);
      acc  = act && m_st == 0 && t_r;
      if (!enable) begin m_delay = 0; m_counting = 0; m_cnt = 0; end
      else if (!act) m_counting = 0;
      else if (acc) begin m_cnt = 0; m_counting = 1; end
      else if (m_counting) begin
        if (fire) begin m_delay = m_cnt; m_counting = 0; end
        else if (m_cnt < MAXV) m_cnt++;
      end
      if (!act) m_st = 0;
      else case (m_st)
        0: if (t_r)  m_st = 1;
        1: if (r_f)  m_st = 2;
        2: if (r_f)  m_st = 3;
        default: if (!lvl) m_st = 0;
      endcase
      if (!enable) begin r_st = 0; m_pulse = t_r; end
      else begin
        m_pulse = fire;
        case (r_st)
          0: if (lvl) r_st = 1;
          1: if (r_r || r_f) r_st = 2;
          default: if (!lvl) r_st = 0;
        endcase
      end
      m_drive = (m_st == 2);
      hr2 = hr1; hr1 = hr0; hr0 = ref_sig;
      hl1 = hl0; hl0 = lin; tq = trig;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (dut_pulse) obs++;
    if (dut_drive) drive_hi++;
    if (cmp_on) begin
      check(dut_drive == m_drive, "R2", "line drive", dut_drive, m_drive);
      check(dut_pulse == m_pulse, "R4", "sync pulse", dut_pulse, m_pulse);
      check(int'(dut_delay) == m_delay, "R6", "delay", dut_delay, m_delay);
      if (dut_pulse && enable) check(!prev_pulse, "R9", "pulse width", 2, 1);
    end
    prev_pulse = dut_pulse;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_trig(input int width);
    trig = 1'b1; tick(width); trig = 1'b0;
  endtask

  initial begin
    int p0, d0;
    tick(4);
    check(dut_drive == 0 && dut_pulse == 0 && dut_delay == 0, "R8", "reset outputs",
          {dut_drive, dut_pulse}, 0);
    rst_n = 1'b1;
    tick(1);
    check(dut_drive == 0 && dut_pulse == 0 && dut_delay == 0, "R8", "release outputs",
          {dut_drive, dut_pulse}, 0);
    cmp_on = 1;
    is_master = 1'b1; enable = 1'b1;
    tick(20);
    for (int ph = 0; ph < 16; ph++) begin
      tick(ph);
      p0 = obs;
      pulse_trig(3);
      tick(70);
      check(obs - p0 == 1, "R4", "master sweep pulse count", obs - p0, 1);
      check(dut_delay > 0, "R6", "master delay nonzero", dut_delay, 1);
    end
    p0 = obs;
    pulse_trig(150);
    tick(70);
    check(obs - p0 == 1, "R1", "held trigger pulse count", obs - p0, 1);
    p0 = obs;
    pulse_trig(1); tick(4); pulse_trig(1); tick(7); pulse_trig(1);
    tick(80);
    check(obs - p0 == 1, "R5", "lockout pulse count", obs - p0, 1);
    is_master = 1'b0;
    tick(40);
    p0 = obs; d0 = drive_hi;
    for (int k = 0; k < 4; k++) begin pulse_trig(2); tick(25); end
    check(obs == p0, "R3", "slave trigger ignored", obs - p0, 0);
    check(drive_hi == d0, "R3", "slave never drives", drive_hi - d0, 0);
    p0 = obs;
    ext_line = 1'b1; tick(24); ext_line = 1'b0; tick(30);
    check(obs - p0 == 1, "R4", "slave receives line", obs - p0, 1);
    enable = 1'b0; is_master = 1'b1;
    tick(3);
    check(dut_delay == 0, "R7", "delay zero when off", dut_delay, 0);
    p0 = obs; d0 = drive_hi;
    pulse_trig(1);
    check(dut_pulse == 1, "R7", "bypass pulse one cycle after rise", dut_pulse, 1);
    tick(1);
    check(dut_pulse == 0, "R7", "bypass pulse ends", dut_pulse, 0);
    tick(60);
    check(obs - p0 == 1 && drive_hi == d0, "R7", "bypass no drive", drive_hi - d0, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule